// File: doc/BRIEF.md
# Three-Input Lookup Table Logic Unit

This block evaluates any boolean function of three inputs across a 64-bit word. It works like a programmable logic cell. For every bit position, one bit from each of three operands forms a 3-bit index. That index selects one entry of an 8-entry truth table. Because the table is supplied with every operation, one datapath covers all 256 three-input bitwise functions. Examples are AND, OR, XOR, select, majority and their inverted forms. No opcode decode is needed.

The first operand is the destination's current value. It takes part in the lookup and also supplies the bits that are left untouched. The table comes from one of two sources:
- an 8-bit immediate, delivered as a 5-bit low field and a 3-bit high field that are joined;
- the low byte of a fourth register operand.

A 2-bit mode selects one of three behaviours:
- plain bitwise evaluation;
- a byte-masked variant, where only the enabled bytes of the low 32 bits are replaced;
- a whole-word test, where each operand is reduced to a single zero/nonzero flag and a single 0 or 1 is returned.

The lookup is combinational and the result is registered. A small two-state sequencer raises the result-valid flag exactly one cycle after an accepted input. Its states are `ST_IDLE` (no new result) and `ST_DONE` (the output register holds the result of the previous cycle's input). It has three transitions:
- `ST_IDLE` to `ST_DONE` when `in_valid` is high;
- `ST_DONE` to `ST_DONE` when `in_valid` is high again;
- `ST_DONE` or `ST_IDLE` to `ST_IDLE` when `in_valid` is low.

Top module: `lut3_logic_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted input, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` was 1, and 0 otherwise. `out_data` changes only at an edge where `in_valid` is 1, and holds its value at every other edge.
- R3: In bitwise mode, result bit i equals table bit number `{op_d[i], op_a[i], op_b[i]}`, with `op_d` the most significant index bit and `op_b` the least.
- R4: With `tbl_from_reg` = 0 the table is `{imm_hi, imm_lo}`, so `imm_hi` supplies table bits 7..5 and `imm_lo` bits 4..0. With `tbl_from_reg` = 1 the table is `op_c[7:0]`, and bits 63..8 of `op_c` have no effect.
- R5: The mode encoding is 2'b00 bitwise, 2'b01 byte-masked and 2'b10 whole-word test. The code 2'b11 behaves exactly like 2'b00.
- R6: In byte-masked mode, bits [8j+7:8j] for j = 0..3 take the bitwise result when `byte_mask[j]` is 1 and keep `op_d` otherwise. Bits 63..32 always keep `op_d`. In every other mode `byte_mask` has no effect.
- R7: In whole-word mode the result is all zeros except bit 0. Bit 0 equals table bit number `{op_d != 0, op_a != 0, op_b != 0}`.
- R8: In bitwise mode:
  - table 0x00 gives all zeros;
  - table 0xFF gives all ones;
  - table 0x96 gives `op_d ^ op_a ^ op_b`;
  - table 0xE8 gives the bitwise majority of the three operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_d | input | 64 | Old destination value; most significant index bit and source of kept bits |
| op_a | input | 64 | Middle index bit operand |
| op_b | input | 64 | Least significant index bit operand |
| op_c | input | 64 | Register table source; only bits 7..0 are used |
| imm_lo | input | 5 | Immediate table bits 4..0 |
| imm_hi | input | 3 | Immediate table bits 7..5 |
| tbl_from_reg | input | 1 | 1 selects `op_c[7:0]` as table, 0 the immediate |
| mode | input | 2 | 00 bitwise, 01 byte-masked, 10 whole-word test, 11 bitwise |
| byte_mask | input | 4 | Per-byte write enable for the low 32 bits in byte-masked mode |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Registered result |

## Verification
The operand pattern 0xF0, 0xCC and 0xAA in every byte of `op_d`, `op_a` and `op_b` walks all eight index values within each byte. With it, the output byte is the table itself. This pattern exposes any swapped index bit, a misjoined immediate field, or a table taken from the wrong source. The four named tables are tried on irregular operands to tell constant, parity and majority functions apart. A mask of alternating bytes separates replaced bytes from kept bytes and the upper half. Whole-word cases put a single set bit at the top of an operand, which shows whether the zero test covers the full width. A long run of random operands, modes and masks, sent back to back and with idle gaps, is compared against a behavioural model on every cycle.

// File: rtl/lut3_pkg.sv
package lut3_pkg;

    // Operation mode carried on the mode input.
    typedef enum logic [1:0] {
        MODE_BIT     = 2'b00,
        MODE_BYTE    = 2'b01,
        MODE_WORD    = 2'b10,
        MODE_BIT_ALT = 2'b11
    } lut_mode_e;

    // Result sequencer states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } out_state_e;

endpackage

// File: rtl/lut3_table_sel.sv
module lut3_table_sel #(
    parameter int TBL_W    = 8,
    parameter int IMM_LO_W = 5,
    localparam int IMM_HI_W = TBL_W - IMM_LO_W
) (
    input  logic [IMM_LO_W-1:0] imm_lo,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [TBL_W-1:0]    reg_tbl,
    input  logic                from_reg,
    output logic [TBL_W-1:0]    tbl
);

    logic [TBL_W-1:0] imm_tbl;

    // The high field supplies the upper table bits.
    assign imm_tbl = {imm_hi, imm_lo};

    always_comb begin
        if (from_reg) begin
            tbl = reg_tbl;
        end else begin
            tbl = imm_tbl;
        end
    end

endmodule

// File: rtl/lut3_bit_eval.sv
module lut3_bit_eval #(
    parameter int DATA_W = 64,
    parameter int TBL_W  = 8
) (
    input  logic [DATA_W-1:0] d_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [TBL_W-1:0]  tbl,
    output logic [DATA_W-1:0] bits_out
);

    // One 8:1 table selector per bit position.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [2:0] idx;
        assign idx         = {d_in[i], a_in[i], b_in[i]};
        assign bits_out[i] = tbl[idx];
    end

endmodule

// File: rtl/lut3_word_eval.sv
module lut3_word_eval #(
    parameter int DATA_W = 64,
    parameter int TBL_W  = 8
) (
    input  logic [DATA_W-1:0] d_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [TBL_W-1:0]  tbl,
    output logic              flag_out
);

    logic       d_nz;
    logic       a_nz;
    logic       b_nz;
    logic [2:0] idx;

    // Each operand collapses to a single nonzero flag.
    assign d_nz     = |d_in;
    assign a_nz     = |a_in;
    assign b_nz     = |b_in;
    assign idx      = {d_nz, a_nz, b_nz};
    assign flag_out = tbl[idx];

endmodule

// File: rtl/lut3_merge.sv
module lut3_merge #(
    parameter int DATA_W = 64,
    parameter int MASK_W = 4,
    parameter int GRP_W  = 8,
    localparam int MASKED_W = MASK_W * GRP_W
) (
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] bit_res,
    input  logic              word_flag,
    input  logic [MASK_W-1:0] byte_mask,
    output logic [DATA_W-1:0] result
);

    import lut3_pkg::*;

    logic [DATA_W-1:0] masked_res;
    logic [DATA_W-1:0] word_res;

    // Byte groups in the covered range pick between new and old bits.
    // Everything above the covered range keeps the old value.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i < MASKED_W) begin : g_cov
            assign masked_res[i] = byte_mask[i / GRP_W] ? bit_res[i] : old_val[i];
        end else begin : g_keep
            assign masked_res[i] = old_val[i];
        end
    end

    always_comb begin
        word_res    = '0;
        word_res[0] = word_flag;
    end

    always_comb begin
        unique case (lut_mode_e'(mode))
            MODE_BYTE:    result = masked_res;
            MODE_WORD:    result = word_res;
            MODE_BIT:     result = bit_res;
            MODE_BIT_ALT: result = bit_res;
            default:      result = bit_res;
        endcase
    end

endmodule

// File: rtl/lut3_logic_unit.sv
module lut3_logic_unit #(
    parameter int DATA_W   = 64,
    parameter int TBL_W    = 8,
    parameter int IMM_LO_W = 5,
    parameter int MASK_W   = 4,
    parameter int GRP_W    = 8,
    localparam int IMM_HI_W = TBL_W - IMM_LO_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   op_d,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [DATA_W-1:0]   op_c,
    input  logic [IMM_LO_W-1:0] imm_lo,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic                tbl_from_reg,
    input  logic [1:0]          mode,
    input  logic [MASK_W-1:0]   byte_mask,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data
);

    import lut3_pkg::*;

    logic [TBL_W-1:0]  tbl;
    logic [DATA_W-1:0] bit_res;
    logic              word_flag;
    logic [DATA_W-1:0] next_res;
    logic              c_hi_unused;

    out_state_e        state_q;
    out_state_e        state_d;
    logic [DATA_W-1:0] data_q;

    // Only the low table byte of the register source matters.
    assign c_hi_unused = ^op_c[DATA_W-1:TBL_W];

    lut3_table_sel #(
        .TBL_W    (TBL_W),
        .IMM_LO_W (IMM_LO_W)
    ) tbl_sel_i (
        .imm_lo   (imm_lo),
        .imm_hi   (imm_hi),
        .reg_tbl  (op_c[TBL_W-1:0]),
        .from_reg (tbl_from_reg),
        .tbl      (tbl)
    );

    lut3_bit_eval #(
        .DATA_W (DATA_W),
        .TBL_W  (TBL_W)
    ) bit_eval_i (
        .d_in     (op_d),
        .a_in     (op_a),
        .b_in     (op_b),
        .tbl      (tbl),
        .bits_out (bit_res)
    );

    lut3_word_eval #(
        .DATA_W (DATA_W),
        .TBL_W  (TBL_W)
    ) word_eval_i (
        .d_in     (op_d),
        .a_in     (op_a),
        .b_in     (op_b),
        .tbl      (tbl),
        .flag_out (word_flag)
    );

    lut3_merge #(
        .DATA_W (DATA_W),
        .MASK_W (MASK_W),
        .GRP_W  (GRP_W)
    ) merge_i (
        .mode      (mode),
        .old_val   (op_d),
        .bit_res   (bit_res),
        .word_flag (word_flag),
        .byte_mask (byte_mask),
        .result    (next_res)
    );

    // Next-state decision of the result sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                data_q <= next_res;
            end
        end
    end

    // Outputs.
    always_comb begin
        out_valid = (state_q == ST_DONE);
        out_data  = data_q;
    end

endmodule

// File: rtl/lut3_logic_unit_chk.sv
module lut3_logic_unit_chk #(
    parameter int DATA_W   = 64,
    parameter int TBL_W    = 8,
    parameter int IMM_LO_W = 5,
    parameter int MASK_W   = 4,
    parameter int GRP_W    = 8,
    localparam int IMM_HI_W = TBL_W - IMM_LO_W,
    localparam int MASKED_W = MASK_W * GRP_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [DATA_W-1:0]   op_d,
    input logic [IMM_LO_W-1:0] imm_lo,
    input logic [IMM_HI_W-1:0] imm_hi,
    input logic                tbl_from_reg,
    input logic [1:0]          mode,
    input logic                out_valid,
    input logic [DATA_W-1:0]   out_data
);

    import lut3_pkg::*;

    // R2: accepted input gives a valid result one cycle later
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no input, no valid result and no change of the output
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R6: upper half passes the old destination in byte-masked mode
    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_BYTE) |=>
            out_data[DATA_W-1:MASKED_W] == $past(op_d[DATA_W-1:MASKED_W]));

    // R7: whole-word mode yields at most bit 0
    assert_word_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_WORD) |=> out_data[DATA_W-1:1] == '0);

    // R8: an all-zero immediate table clears the word in bitwise mode
    assert_zero_table_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !tbl_from_reg && mode == MODE_BIT && {imm_hi, imm_lo} == '0)
            |=> out_data == '0);

endmodule

bind lut3_logic_unit lut3_logic_unit_chk #(
    .DATA_W   (DATA_W),
    .TBL_W    (TBL_W),
    .IMM_LO_W (IMM_LO_W),
    .MASK_W   (MASK_W),
    .GRP_W    (GRP_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_d         (op_d),
    .imm_lo       (imm_lo),
    .imm_hi       (imm_hi),
    .tbl_from_reg (tbl_from_reg),
    .mode         (mode),
    .out_valid    (out_valid),
    .out_data     (out_data)
);

// File: tb/lut3_logic_unit_tb.sv
module lut3_logic_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_d = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [63:0] op_c = '0;
    logic [4:0]  imm_lo = '0;
    logic [2:0]  imm_hi = '0;
    logic        tbl_from_reg = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [3:0]  byte_mask = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_out = '0;

    localparam logic [63:0] PAT_D = {8{8'hF0}};
    localparam logic [63:0] PAT_A = {8{8'hCC}};
    localparam logic [63:0] PAT_B = {8{8'hAA}};

    always #5 clk = ~clk;

    lut3_logic_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .op_d         (op_d),
        .op_a         (op_a),
        .op_b         (op_b),
        .op_c         (op_c),
        .imm_lo       (imm_lo),
        .imm_hi       (imm_hi),
        .tbl_from_reg (tbl_from_reg),
        .mode         (mode),
        .byte_mask    (byte_mask),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

    // Behavioural reference built from the requirements.
    function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] c,
                                          input logic [4:0] lo, input logic [2:0] hi,
                                          input logic sel, input logic [1:0] md,
                                          input logic [3:0] msk);
        logic [7:0]  t;
        logic [63:0] r;
        int          k;
        t = sel ? c[7:0] : {hi, lo};
        r = '0;
        if (md == 2'b10) begin
            k = ((d != 0) ? 4 : 0) + ((a != 0) ? 2 : 0) + ((b != 0) ? 1 : 0);
            r[0] = t[k];
        end else begin
            for (int i = 0; i < 64; i++) begin
                k = (d[i] ? 4 : 0) + (a[i] ? 2 : 0) + (b[i] ? 1 : 0);
                r[i] = t[k];
                if (md == 2'b01 && (i >= 32 || !msk[i / 8])) r[i] = d[i];
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Model sampling at the active edge.
    always @(posedge clk) begin
        cycles++;
        if (rst_n && in_valid) begin
            exp_q.push_back(model(op_d, op_a, op_b, op_c, imm_lo, imm_hi,
                                  tbl_from_reg, mode, byte_mask));
            tag_q.push_back("R3/R5/R6/R7");
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 valid", {63'b0, out_valid}, {63'b0, (exp_q.size() != 0)});
            if (exp_q.size() != 0) begin
                logic [63:0] e;
                string       tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(tg, out_data, e);
                last_out = e;
            end else begin
                check("R2 hold", out_data, last_out);
            end
        end
    end

    task automatic drive(input logic [63:0] d, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] c, input logic [7:0] t, input logic sel,
                         input logic [1:0] md, input logic [3:0] msk);
        @(negedge clk);
        in_valid     = 1'b1;
        op_d         = d;
        op_a         = a;
        op_b         = b;
        op_c         = c;
        imm_lo       = t[4:0];
        imm_hi       = t[7:5];
        tbl_from_reg = sel;
        mode         = md;
        byte_mask    = msk;
    endtask

    // Single operation with a hand-computed expected value.
    task automatic directed(input string req, input logic [63:0] d, input logic [63:0] a,
                            input logic [63:0] b, input logic [63:0] c, input logic [7:0] t,
                            input logic sel, input logic [1:0] md, input logic [3:0] msk,
                            input logic [63:0] expv);
        drive(d, a, b, c, t, sel, md, msk);
        @(negedge clk);
        check(req, out_data, expv);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        logic [63:0] d0;
        logic [63:0] a0;
        logic [63:0] b0;
        d0 = 64'h0123_4567_89AB_CDEF;
        a0 = 64'hFEDC_BA98_7654_3210;
        b0 = 64'h5A5A_0FF0_3C3C_9669;

        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'b0, out_valid}, 64'd0);
        check("R1 reset data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", out_data, 64'd0);

        // R8: named tables
        directed("R8 table00", d0, a0, b0, '0, 8'h00, 1'b0, 2'b00, 4'hF, 64'd0);
        directed("R8 tableFF", d0, a0, b0, '0, 8'hFF, 1'b0, 2'b00, 4'h0, {64{1'b1}});
        directed("R8 xor3", d0, a0, b0, '0, 8'h96, 1'b0, 2'b00, 4'h3, d0 ^ a0 ^ b0);
        directed("R8 majority", d0, a0, b0, '0, 8'hE8, 1'b0, 2'b00, 4'h0,
                 (d0 & a0) | (d0 & b0) | (a0 & b0));

        // R3 and R4: walking pattern returns the table in every byte
        directed("R3/R4 imm table", PAT_D, PAT_A, PAT_B, 64'hFFFF_FFFF_FFFF_FF00,
                 8'h5A, 1'b0, 2'b00, 4'h0, {8{8'h5A}});
        directed("R4 reg table", PAT_D, PAT_A, PAT_B, 64'hDEAD_BEEF_0BAD_F037,
                 8'hFF, 1'b1, 2'b00, 4'h0, {8{8'h37}});
        directed("R4 reg upper ignored", PAT_D, PAT_A, PAT_B, 64'h0000_0000_0000_0037,
                 8'h00, 1'b1, 2'b00, 4'h0, {8{8'h37}});

        // R5: code 11 equals bitwise
        directed("R5 mode11", PAT_D, PAT_A, PAT_B, '0, 8'hC3, 1'b0, 2'b11, 4'hA, {8{8'hC3}});

        // R6: masked bytes and ignored mask in other modes
        directed("R6 mask0101", PAT_D, PAT_A, PAT_B, '0, 8'h00, 1'b0, 2'b01, 4'b0101,
                 64'hF0F0_F0F0_F000_F000);
        directed("R6 mask all", PAT_D, PAT_A, PAT_B, '0, 8'h0F, 1'b0, 2'b01, 4'b1111,
                 64'hF0F0_F0F0_0F0F_0F0F);
        directed("R6 mask ignored", d0, a0, b0, '0, 8'hFF, 1'b0, 2'b00, 4'b0000, {64{1'b1}});

        // R7: whole-word test
        directed("R7 idx2 hit", '0, 64'h5, '0, '0, 8'h04, 1'b0, 2'b10, 4'hF, 64'd1);
        directed("R7 idx2 miss", '0, 64'h5, '0, '0, 8'hFB, 1'b0, 2'b10, 4'h0, 64'd0);
        directed("R7 top bit", 64'h8000_0000_0000_0000, '0, 64'h1, '0, 8'h20, 1'b0,
                 2'b10, 4'h0, 64'd1);
        directed("R7 reg table", '0, '0, '0, 64'hFFFF_FFFF_FFFF_FF01, 8'h00, 1'b1,
                 2'b10, 4'h0, 64'd1);

        // R2: idle cycles keep the output
        idle(4);

        // Random traffic, back to back with occasional gaps
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 5) == 0) begin
                idle(1 + ($urandom % 3));
            end else begin
                drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                      {$urandom, $urandom}, 8'($urandom), 1'($urandom), 2'($urandom),
                      4'($urandom));
            end
        end
        idle(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cycles > 50000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<50000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule